// File: doc/BRIEF.md
# Duplex LCD Frame Generator and Segment Multiplexer

This block turns a bank of held display bits into the drive pattern for a liquid-crystal panel with two backplanes. The bits are stored as pairs, one pair per segment line. Each pair has a first bit, shown while backplane one is active, and a second bit, shown while backplane two is active. A two-stage divider runs from the multiplex clock. It produces a phase signal that toggles on every enabled clock and an inversion signal that toggles at half that rate. Together the two signals step through a four-phase frame that keeps the panel AC-balanced.

Each segment line shows the selected bit of its pair, XORed with the inversion signal. The two backplane outputs are 2-bit level codes that an analog driver turns into high, mid and low voltages. The multiplex clock is gated by an enable input. This lets a device further down a cascade run from a clock forwarded by the first device, and it freezes the frame whenever the enable is low.

Top module: `lcdx_duplex_drive`

## Requirements
- R1: A synchronous active-high reset sets both the phase output and the inversion output to 0 at the next clock edge.
- R2: On every rising clock edge with reset low and `mux_en` high, `phase_common` inverts.
- R3: `phase_inv` inverts on an enabled edge where `phase_common` is 1 before the edge, and holds otherwise. The frame therefore cycles through (common, inv) = (0,0), (1,0), (0,1), (1,1).
- R4: On an edge where `mux_en` is low and reset is low, both `phase_common` and `phase_inv` keep their values.
- R5: For every pair n, `pair_bits[2n]` is the first bit and `pair_bits[2n+1]` is the second bit. `seg_out[n]` equals (`phase_common` ? second : first) XOR `phase_inv`.
- R6: Backplane codes take only the values 2'b10 (high), 2'b01 (mid) and 2'b00 (low). The value 2'b11 never appears.
- R7: While `phase_common` is 0, `bp1_code` is high if `phase_inv` is 1 and low if it is 0, and `bp2_code` is mid.
- R8: While `phase_common` is 1, `bp2_code` is high if `phase_inv` is 1 and low if it is 0, and `bp1_code` is mid.
- R9: Reset takes priority over `mux_en` when both are high on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Multiplex clock |
| rst | input | 1 | Synchronous active-high reset |
| mux_en | input | 1 | Gates the multiplex clock into the divider |
| pair_bits | input | 2*NUM_PAIRS | Held display bits; bit 2n is the first bit of pair n, bit 2n+1 is the second |
| phase_common | output | 1 | Frame phase: selects which bit of each pair is shown |
| phase_inv | output | 1 | Polarity inversion signal at half the phase rate |
| seg_out | output | NUM_PAIRS | Segment line data after selection and inversion |
| bp1_code | output | 2 | Level code for backplane one |
| bp2_code | output | 2 | Level code for backplane two |

## Verification
Two behaviours can fall on the same clock edge. The first is reset against an enabled divider step. The bench raises reset together with `mux_en` while the frame sits in a non-zero phase, and it expects the all-zero phase rather than an advance. The second is the inversion flip on the edge where the phase falls from 1 to 0. The bench walks the full four-phase frame several times and compares each phase pair with its own arithmetic model. In every phase, it also sweeps all pair patterns of a small 8-pair configuration across the segment lines and checks the backplane codes.

// File: rtl/lcdx_pkg.sv
package lcdx_pkg;

    localparam int unsigned BITS_PER_PAIR = 2;
    localparam int unsigned NUM_BACKPLANES = 2;

    typedef enum logic [1:0] {
        BP_LOW  = 2'b00,
        BP_MID  = 2'b01,
        BP_HIGH = 2'b10
    } bp_level_e;

    typedef struct packed {
        logic common;
        logic inv;
    } frame_phase_t;

    // Level for the backplane that is currently selected by the phase.
    function automatic bp_level_e active_level(input logic inv);
        return inv ? BP_HIGH : BP_LOW;
    endfunction

    // Select one bit of a pair by phase, then apply the polarity flip.
    function automatic logic pick_bit(input logic first_bit,
                                      input logic second_bit,
                                      input frame_phase_t ph);
        return (ph.common ? second_bit : first_bit) ^ ph.inv;
    endfunction

endpackage

// File: rtl/lcdx_frame_div.sv
module lcdx_frame_div
    import lcdx_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    output frame_phase_t phase
);

    frame_phase_t phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (en) begin
            phase_q.common <= ~phase_q.common;
            if (phase_q.common) begin
                phase_q.inv <= ~phase_q.inv;
            end
        end
    end

    assign phase = phase_q;

endmodule

// File: rtl/lcdx_seg_mux.sv
module lcdx_seg_mux
    import lcdx_pkg::*;
#(
    parameter int unsigned NUM_PAIRS = 140
) (
    input  logic [BITS_PER_PAIR*NUM_PAIRS-1:0] pair_bits,
    input  frame_phase_t                       phase,
    output logic [NUM_PAIRS-1:0]               seg
);

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        localparam int unsigned FIRST_IDX  = BITS_PER_PAIR * g;
        localparam int unsigned SECOND_IDX = BITS_PER_PAIR * g + 1;
        assign seg[g] = pick_bit(pair_bits[FIRST_IDX], pair_bits[SECOND_IDX], phase);
    end

endmodule

// File: rtl/lcdx_backplane_enc.sv
module lcdx_backplane_enc
    import lcdx_pkg::*;
(
    input  frame_phase_t phase,
    output bp_level_e    level [NUM_BACKPLANES]
);

    for (genvar k = 0; k < NUM_BACKPLANES; k++) begin : g_bp
        localparam logic SEL = (k == 1);
        always_comb begin
            if (phase.common == SEL) begin
                level[k] = active_level(phase.inv);
            end else begin
                level[k] = BP_MID;
            end
        end
    end

endmodule

// File: rtl/lcdx_duplex_drive.sv
module lcdx_duplex_drive
    import lcdx_pkg::*;
#(
    parameter int unsigned NUM_PAIRS = 140
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 mux_en,
    input  logic [BITS_PER_PAIR*NUM_PAIRS-1:0]   pair_bits,
    output logic                                 phase_common,
    output logic                                 phase_inv,
    output logic [NUM_PAIRS-1:0]                 seg_out,
    output logic [1:0]                           bp1_code,
    output logic [1:0]                           bp2_code
);

    frame_phase_t phase;
    bp_level_e    bp_level [NUM_BACKPLANES];

    lcdx_frame_div u_div (
        .clk   (clk),
        .rst   (rst),
        .en    (mux_en),
        .phase (phase)
    );

    lcdx_seg_mux #(
        .NUM_PAIRS (NUM_PAIRS)
    ) u_seg (
        .pair_bits (pair_bits),
        .phase     (phase),
        .seg       (seg_out)
    );

    lcdx_backplane_enc u_bp (
        .phase (phase),
        .level (bp_level)
    );

    assign phase_common = phase.common;
    assign phase_inv    = phase.inv;
    assign bp1_code     = bp_level[0];
    assign bp2_code     = bp_level[1];

endmodule

// File: rtl/lcdx_duplex_drive_chk.sv
module lcdx_duplex_drive_chk #(
    parameter int unsigned NUM_PAIRS = 140
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   mux_en,
    input logic [2*NUM_PAIRS-1:0] pair_bits,
    input logic                   phase_common,
    input logic                   phase_inv,
    input logic [NUM_PAIRS-1:0]   seg_out,
    input logic [1:0]             bp1_code,
    input logic [1:0]             bp2_code
);

    localparam int unsigned LAST = NUM_PAIRS - 1;

    // R1 and R9: reset wins and clears the frame
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!phase_common && !phase_inv));

    p_common_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!rst && mux_en) |=> (phase_common != $past(phase_common)));

    p_inv_flip_r3: assert property (@(posedge clk) disable iff (rst)
        (!rst && mux_en && phase_common) |=> (phase_inv != $past(phase_inv)));

    p_inv_keep_r3: assert property (@(posedge clk) disable iff (rst)
        (!rst && mux_en && !phase_common) |=> $stable(phase_inv));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!rst && !mux_en) |=> ($stable(phase_common) && $stable(phase_inv)));

    p_seg_first_r5: assert property (@(posedge clk) disable iff (rst)
        seg_out[0] == ((phase_common ? pair_bits[1] : pair_bits[0]) ^ phase_inv));

    p_seg_last_r5: assert property (@(posedge clk) disable iff (rst)
        seg_out[LAST] == ((phase_common ? pair_bits[2*LAST+1] : pair_bits[2*LAST]) ^ phase_inv));

    p_code_legal_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bp1_code) && $onehot0(bp2_code));

    p_bp_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !phase_common |-> (bp2_code == 2'b01 && bp1_code == {phase_inv, 1'b0}));

    p_bp_idle_r8: assert property (@(posedge clk) disable iff (rst)
        phase_common |-> (bp1_code == 2'b01 && bp2_code == {phase_inv, 1'b0}));

endmodule

bind lcdx_duplex_drive lcdx_duplex_drive_chk #(
    .NUM_PAIRS (NUM_PAIRS)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .mux_en       (mux_en),
    .pair_bits    (pair_bits),
    .phase_common (phase_common),
    .phase_inv    (phase_inv),
    .seg_out      (seg_out),
    .bp1_code     (bp1_code),
    .bp2_code     (bp2_code)
);

// File: tb/lcdx_duplex_drive_tb.sv
module lcdx_duplex_drive_tb_top;

    localparam int unsigned NP = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            mux_en = 1'b0;
    logic [2*NP-1:0] pair_bits = '0;
    logic            phase_common;
    logic            phase_inv;
    logic [NP-1:0]   seg_out;
    logic [1:0]      bp1_code;
    logic [1:0]      bp2_code;

    int checks = 0;
    int failures = 0;
    logic m_common = 1'b0;
    logic m_inv = 1'b0;

    always #4 clk = ~clk;

    lcdx_duplex_drive #(.NUM_PAIRS(NP)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .mux_en       (mux_en),
        .pair_bits    (pair_bits),
        .phase_common (phase_common),
        .phase_inv    (phase_inv),
        .seg_out      (seg_out),
        .bp1_code     (bp1_code),
        .bp2_code     (bp2_code)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive at the falling edge, update the model at the rising edge, settle.
    task automatic step(input logic r, input logic e);
        @(negedge clk);
        rst = r;
        mux_en = e;
        @(posedge clk);
        if (r) begin
            m_common = 1'b0;
            m_inv = 1'b0;
        end else if (e) begin
            if (m_common) m_inv = ~m_inv;
            m_common = ~m_common;
        end
        #2;
    endtask

    task automatic check_phase(input string req);
        check(req, {30'd0, phase_common, phase_inv}, {30'd0, m_common, m_inv});
    endtask

    task automatic check_bp();
        logic [1:0] act_lvl;
        act_lvl = m_inv ? 2'b10 : 2'b00;
        if (!m_common) begin
            check("R7 bp1", {30'd0, bp1_code}, {30'd0, act_lvl});
            check("R7 bp2", {30'd0, bp2_code}, 32'd1);
        end else begin
            check("R8 bp1", {30'd0, bp1_code}, 32'd1);
            check("R8 bp2", {30'd0, bp2_code}, {30'd0, act_lvl});
        end
        check("R6 legal", {31'd0, (bp1_code == 2'b11) || (bp2_code == 2'b11)}, 32'd0);
    endtask

    task automatic sweep_segments();
        for (int v = 0; v < (1 << (2*NP)); v++) begin
            logic [NP-1:0] exp_seg;
            pair_bits = v[2*NP-1:0];
            for (int n = 0; n < NP; n++) begin
                logic b1;
                logic b2;
                b1 = pair_bits[2*n];
                b2 = pair_bits[2*n+1];
                exp_seg[n] = (m_common ? b2 : b1) ^ m_inv;
            end
            #1;
            check("R5 seg", {24'd0, seg_out}, {24'd0, exp_seg});
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        // R1: reset state
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        check_phase("R1 reset");
        check_bp();

        // R2, R3: walk the four-phase frame three times
        for (int i = 0; i < 12; i++) begin
            step(1'b0, 1'b1);
            check_phase("R2 R3 frame step");
            check_bp();
        end

        // R4: irregular enable pattern, holds on disabled edges
        for (int i = 0; i < 16; i++) begin
            logic e;
            e = ((i * 5 + 3) % 7) < 3;
            step(1'b0, e);
            check_phase(e ? "R3 enabled step" : "R4 hold");
        end

        // R9: reset together with enable from a non-zero phase
        step(1'b0, 1'b1);
        if (!m_common && !m_inv) step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        check_phase("R9 reset over enable");

        // R5 per phase, with R4 holding the frame during each sweep
        for (int p = 0; p < 4; p++) begin
            if (p != 0) step(1'b0, 1'b1);
            mux_en = 1'b0;
            check_bp();
            sweep_segments();
            check_phase("R4 hold during sweep");
        end

        finish_run();
    end

endmodule